// File: doc/BRIEF.md
# Extended Instruction Group Decoder

This block sits at the front of a small 16-bit accumulator CPU. It sorts each fetched instruction into one of eight groups by its top three bits. It carries out the groups that need no ALU. These are constant loads into the A register, loads of a 14-bit segment (address-extension) register, and a sub-group of extended operations. One of the extended operations forces the sign bit of A, so negative constants can be built without an arithmetic step.

The block owns the A register and the segment register. It joins them into a 29-bit extended address, which serves both data accesses and jump targets. Compute instructions (group 7) change no local state. They are handed onward through a one-cycle strobe together with the instruction word, for an ALU stage outside this block.

All state updates and strobes appear one clock after an instruction is accepted with `instr_valid` high. The extended address is always the registered segment placed above the low 15 bits of the registered A.

Top module: `xgrp_decoder`

## Requirements
- R1: On synchronous active-high reset, A, the segment register, `ext_addr`, `grp_code`, `compute_valid`, `illegal_op` and `compute_instr` all become zero.
- R2: A valid instruction with bit 15 = 0 (groups 0 to 3) loads A with bit 15 cleared and bits 14:0 from the instruction. The new value is visible on the next cycle, and any sign bit set earlier is dropped.
- R3: A valid instruction with bits 15:14 = 10 loads the segment register from instruction bits 13:0 and leaves A unchanged.
- R4: `ext_addr` always equals the segment register in bits 28:15 above A bits 14:0.
- R5: A valid instruction with bits 15:13 = 110 and bits 12:0 = 0 sets A bit 15 to 1. A bits 14:0 and the segment register stay unchanged. Repeating it leaves A unchanged.
- R6: A valid instruction with bits 15:13 = 110 and any nonzero bits 12:0 raises `illegal_op` for exactly one cycle, on the next cycle, and changes neither A nor the segment register.
- R7: A valid instruction with bits 15:13 = 111 raises `compute_valid` for exactly one cycle, on the next cycle, with `compute_instr` equal to the instruction, and changes neither A nor the segment register.
- R8: While `instr_valid` is low, A, the segment register and `grp_code` hold, and `compute_valid` and `illegal_op` are low on the next cycle.
- R9: `grp_code` shows bits 15:13 of the most recent valid instruction, from the cycle after it was accepted.
- R10: A sign bit set by R5 survives later segment loads, compute instructions and reserved operations, until the next constant load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 16 | Fetched instruction word |
| ext_addr | output | 29 | Segment register above A bits 14:0 |
| a_value | output | 16 | Current A register |
| grp_code | output | 3 | Group of the last accepted instruction |
| compute_valid | output | 1 | One-cycle strobe for a group-7 instruction |
| compute_instr | output | 16 | Group-7 instruction word, held with the strobe |
| illegal_op | output | 1 | One-cycle pulse for a reserved extended code |

## Verification
State errors show on the ports one cycle after the instruction that caused them. A wrong A or segment value shows at once in `a_value` and in `ext_addr`, because both are driven straight from the registers. A sign bit that lingers or is lost shows only in `a_value` bit 15, since the address drops that bit. The stimulus therefore reads A after every step. A misrouted group shows as a wrong `grp_code`, or as a strobe that is missing or extra one cycle after the instruction.

// File: rtl/xgrp_pkg.sv
package xgrp_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned SEG_W  = 14;
    localparam int unsigned GRP_W  = 3;
    localparam int unsigned OFF_W  = WORD_W - 1;
    localparam int unsigned XADR_W = SEG_W + OFF_W;
    localparam int unsigned XOP_W  = WORD_W - GRP_W;

    typedef enum logic [1:0] {
        CLS_CONST   = 2'd0,
        CLS_SEG     = 2'd1,
        CLS_EXT     = 2'd2,
        CLS_COMPUTE = 2'd3
    } instr_class_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [SEG_W-1:0]  seg;
        logic [GRP_W-1:0]  grp;
        logic              cv;
        logic [WORD_W-1:0] cinstr;
        logic              ill;
    } xgrp_state_t;

endpackage

// File: rtl/xgrp_class_dec.sv
module xgrp_class_dec
    import xgrp_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0]     word,
    output instr_class_e     cls,
    output logic [GRP_W-1:0] grp
);

    localparam int unsigned TOP = W - 1;

    assign grp = word[TOP -: GRP_W];

    always_comb begin
        if (!word[TOP]) begin
            cls = CLS_CONST;
        end else if (!word[TOP-1]) begin
            cls = CLS_SEG;
        end else if (!word[TOP-2]) begin
            cls = CLS_EXT;
        end else begin
            cls = CLS_COMPUTE;
        end
    end

endmodule

// File: rtl/xgrp_ext_dec.sv
module xgrp_ext_dec
    import xgrp_pkg::*;
#(
    parameter int unsigned      OPW       = XOP_W,
    parameter logic [OPW-1:0]   SETNEG_OP = '0
) (
    input  logic           en,
    input  logic [OPW-1:0] op,
    output logic           set_neg,
    output logic           reserved
);

    logic hit;

    assign hit      = (op == SETNEG_OP);
    assign set_neg  = en && hit;
    assign reserved = en && !hit;

endmodule

// File: rtl/xgrp_addr_join.sv
module xgrp_addr_join #(
    parameter int unsigned SW = 14,
    parameter int unsigned OW = 15
) (
    input  logic [SW-1:0]    seg,
    input  logic [OW:0]      a,
    output logic [SW+OW-1:0] addr
);

    genvar gi;
    generate
        for (gi = 0; gi < SW + OW; gi++) begin : g_bit
            if (gi < OW) begin : g_off
                assign addr[gi] = a[gi];
            end else begin : g_seg
                assign addr[gi] = seg[gi-OW];
            end
        end
    endgenerate

endmodule

// File: rtl/xgrp_decoder.sv
module xgrp_decoder
    import xgrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    output logic [XADR_W-1:0] ext_addr,
    output logic [WORD_W-1:0] a_value,
    output logic [GRP_W-1:0]  grp_code,
    output logic              compute_valid,
    output logic [WORD_W-1:0] compute_instr,
    output logic              illegal_op
);

    instr_class_e     cls;
    logic [GRP_W-1:0] grp_now;
    logic             set_neg;
    logic             reserved;
    xgrp_state_t      st_d, st_q;

    xgrp_class_dec #(.W(WORD_W)) u_cls (
        .word (instr),
        .cls  (cls),
        .grp  (grp_now)
    );

    xgrp_ext_dec #(.OPW(XOP_W), .SETNEG_OP('0)) u_ext (
        .en       (instr_valid && (cls == CLS_EXT)),
        .op       (instr[XOP_W-1:0]),
        .set_neg  (set_neg),
        .reserved (reserved)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cv  = 1'b0;
        st_d.ill = 1'b0;
        if (instr_valid) begin
            st_d.grp = grp_now;
            unique case (cls)
                CLS_CONST: st_d.a = {1'b0, instr[OFF_W-1:0]};
                CLS_SEG:   st_d.seg = instr[SEG_W-1:0];
                CLS_EXT: begin
                    if (set_neg) begin
                        st_d.a[WORD_W-1] = 1'b1;
                    end
                    st_d.ill = reserved;
                end
                CLS_COMPUTE: begin
                    st_d.cv     = 1'b1;
                    st_d.cinstr = instr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    xgrp_addr_join #(.SW(SEG_W), .OW(OFF_W)) u_join (
        .seg  (st_q.seg),
        .a    (st_q.a),
        .addr (ext_addr)
    );

    assign a_value       = st_q.a;
    assign grp_code      = st_q.grp;
    assign compute_valid = st_q.cv;
    assign compute_instr = st_q.cinstr;
    assign illegal_op    = st_q.ill;

endmodule

// File: rtl/xgrp_decoder_chk.sv
module xgrp_decoder_chk
    import xgrp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr,
    input logic [XADR_W-1:0] ext_addr,
    input logic [WORD_W-1:0] a_value,
    input logic [GRP_W-1:0]  grp_code,
    input logic              compute_valid,
    input logic [WORD_W-1:0] compute_instr,
    input logic              illegal_op
);

    // R1
    property reset_clears_p;
        @(posedge clk) rst |=> (a_value == '0 && ext_addr == '0 && !compute_valid && !illegal_op);
    endproperty
    reset_clears_chk: assert property (reset_clears_p);

    // R2
    property const_load_p;
        @(posedge clk) disable iff (rst)
        (instr_valid && !instr[15]) |=> (a_value == {1'b0, $past(instr[14:0])});
    endproperty
    const_load_chk: assert property (const_load_p);

    // R3
    property seg_load_p;
        @(posedge clk) disable iff (rst)
        (instr_valid && instr[15:14] == 2'b10) |=>
            (ext_addr[XADR_W-1:OFF_W] == $past(instr[SEG_W-1:0]) && $stable(a_value));
    endproperty
    seg_load_chk: assert property (seg_load_p);

    // R4
    property addr_join_p;
        @(posedge clk) disable iff (rst) ext_addr[OFF_W-1:0] == a_value[OFF_W-1:0];
    endproperty
    addr_join_chk: assert property (addr_join_p);

    // R5
    property setneg_p;
        @(posedge clk) disable iff (rst)
        (instr_valid && instr == 16'hC000) |=>
            (a_value[15] && $stable(a_value[14:0]) && $stable(ext_addr));
    endproperty
    setneg_chk: assert property (setneg_p);

    // R6
    property reserved_p;
        @(posedge clk) disable iff (rst)
        (instr_valid && instr[15:13] == 3'b110 && instr[12:0] != '0) |=>
            (illegal_op && $stable(a_value) && $stable(ext_addr));
    endproperty
    reserved_chk: assert property (reserved_p);

    // R7
    property compute_p;
        @(posedge clk) disable iff (rst)
        (instr_valid && instr[15:13] == 3'b111) |=>
            (compute_valid && compute_instr == $past(instr) && $stable(a_value) && $stable(ext_addr));
    endproperty
    compute_chk: assert property (compute_p);

    // R8
    property idle_p;
        @(posedge clk) disable iff (rst)
        !instr_valid |=> (!compute_valid && !illegal_op && $stable(a_value)
                          && $stable(ext_addr) && $stable(grp_code));
    endproperty
    idle_chk: assert property (idle_p);

    // R9
    property grp_track_p;
        @(posedge clk) disable iff (rst)
        instr_valid |=> (grp_code == $past(instr[15:13]));
    endproperty
    grp_track_chk: assert property (grp_track_p);

    // R6 R7
    property pulse_excl_p;
        @(posedge clk) disable iff (rst) !(compute_valid && illegal_op);
    endproperty
    pulse_excl_chk: assert property (pulse_excl_p);

endmodule

bind xgrp_decoder xgrp_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .instr         (instr),
    .ext_addr      (ext_addr),
    .a_value       (a_value),
    .grp_code      (grp_code),
    .compute_valid (compute_valid),
    .compute_instr (compute_instr),
    .illegal_op    (illegal_op)
);

// File: tb/xgrp_decoder_tb.sv
module xgrp_decoder_tb;

    typedef struct packed {
        logic        vld;
        logic [15:0] ins;
        logic [15:0] ea;
        logic [13:0] es;
        logic [2:0]  eg;
        logic        ecv;
        logic        eil;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b1, 16'h1234, 16'h1234, 14'h0000, 3'd0, 1'b0, 1'b0}, // R2
        '{1'b1, 16'h8005, 16'h1234, 14'h0005, 3'd4, 1'b0, 1'b0}, // R3
        '{1'b1, 16'hC000, 16'h9234, 14'h0005, 3'd6, 1'b0, 1'b0}, // R5
        '{1'b1, 16'hA003, 16'h9234, 14'h2003, 3'd5, 1'b0, 1'b0}, // R3 R10
        '{1'b1, 16'hE123, 16'h9234, 14'h2003, 3'd7, 1'b1, 1'b0}, // R7 R10
        '{1'b1, 16'hC001, 16'h9234, 14'h2003, 3'd6, 1'b0, 1'b1}, // R6 R10
        '{1'b0, 16'h7FFF, 16'h9234, 14'h2003, 3'd6, 1'b0, 1'b0}, // R8
        '{1'b1, 16'h7FFF, 16'h7FFF, 14'h2003, 3'd3, 1'b0, 1'b0}, // R2 R10
        '{1'b1, 16'hBFFF, 16'h7FFF, 14'h3FFF, 3'd5, 1'b0, 1'b0}, // R3
        '{1'b1, 16'hDFFF, 16'h7FFF, 14'h3FFF, 3'd6, 1'b0, 1'b1}, // R6
        '{1'b1, 16'hC000, 16'hFFFF, 14'h3FFF, 3'd6, 1'b0, 1'b0}, // R5
        '{1'b1, 16'h0000, 16'h0000, 14'h3FFF, 3'd0, 1'b0, 1'b0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr;
    logic [28:0] ext_addr;
    logic [15:0] a_value;
    logic [2:0]  grp_code;
    logic        compute_valid;
    logic [15:0] compute_instr;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xgrp_decoder u_dut (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .instr         (instr),
        .ext_addr      (ext_addr),
        .a_value       (a_value),
        .grp_code      (grp_code),
        .compute_valid (compute_valid),
        .compute_instr (compute_instr),
        .illegal_op    (illegal_op)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] w);
        @(negedge clk);
        instr_valid = v;
        instr       = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [15:0] ea, input logic [13:0] es,
                             input logic [2:0] eg, input logic ecv, input logic eil);
        check(req, "a_value", {16'h0, a_value}, {16'h0, ea});
        check("R4", "ext_addr", {3'b0, ext_addr}, {3'b0, es, ea[14:0]});
        check(req, "grp_code", {29'h0, grp_code}, {29'h0, eg});
        check(req, "compute_valid", {31'h0, compute_valid}, {31'h0, ecv});
        check(req, "illegal_op", {31'h0, illegal_op}, {31'h0, eil});
    endtask

    initial begin
        rst = 1'b1;
        instr_valid = 1'b0;
        instr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1", 16'h0, 14'h0, 3'd0, 1'b0, 1'b0);
        check("R1", "compute_instr", {16'h0, compute_instr}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VT[i].vld, VT[i].ins);
            check_all($sformatf("R9 vec%0d", i), VT[i].ea, VT[i].es, VT[i].eg, VT[i].ecv, VT[i].eil);
            if (VT[i].ecv) begin
                check("R7", "compute_instr", {16'h0, compute_instr}, {16'h0, VT[i].ins});
            end
        end

        // R7: strobe lasts one cycle only
        step(1'b1, 16'hFFFF);
        check("R7", "compute_instr", {16'h0, compute_instr}, 32'hFFFF);
        @(negedge clk);
        check("R7", "compute_valid drop", {31'h0, compute_valid}, 32'h0);

        // R6: pulse lasts one cycle only
        step(1'b1, 16'hC100);
        check("R6", "illegal_op", {31'h0, illegal_op}, 32'h1);
        @(negedge clk);
        check("R6", "illegal_op drop", {31'h0, illegal_op}, 32'h0);

        // R5 then R8: sign held while idle, then R2 clears it
        step(1'b1, 16'h4321);
        step(1'b1, 16'hC000);
        check("R5", "a_value", {16'h0, a_value}, 32'hC321);
        repeat (3) @(negedge clk);
        check("R8", "a_value idle", {16'h0, a_value}, 32'hC321);
        step(1'b1, 16'h0321);
        check("R2", "sign cleared", {16'h0, a_value}, 32'h0321);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_all("R1", 16'h0, 14'h0, 3'd0, 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule